// File: doc/BRIEF.md
# Bit-Programmable Parallel Port

This block is one 8-bit parallel port on a processor I/O bus. It has a data register and a control register. Software writes a sequence of control bytes to pick a mode. In bit-control mode, every line can be set as an input or an output on its own. Writes to the data register fill an output latch, and a driven line shows the latch value. A read of the data register returns a mix of two sources: the live pin value on input lines and the latched value on output lines.

The control register does not decode every byte as a command. A bit-control mode word arms the register, and the next control write is then taken whole as the direction mask. This holds even when that byte looks like a command. The register also recognises an interrupt control word but otherwise ignores it. Bytes that are not recognised are dropped.

The bus has no back-pressure. A write strobe is accepted in the cycle it is high and takes effect on the next clock edge. Read data is combinational and is valid in the same cycle as the read strobe. The pins appear as an input bus, an output-value bus and a per-line output-enable bus.

Top module: `pport_bitctl`

## Requirements
- R1: After reset, or while the port is not in bit-control mode, every line is an input. `port_oe` is 0, `port_out` is 0 after reset, and a data read returns `pin_in`.
- R2: A write to offset 0 loads the output latch on the next clock edge, whatever the direction of each line. `port_out` always shows the latch.
- R3: A control write (offset 2) whose low nibble is 4'b1111 is a mode word, and bits 7:6 select the mode. The value 2'b11 enters bit-control mode and arms the register to take a mask.
- R4: While the register is armed, the next control write is stored as the direction mask, where bit 1 means input and bit 0 means output. The register then disarms. In bit-control mode, `port_oe[i]` is the inverse of mask bit i.
- R5: Once armed, the register takes any byte as the mask, including 8'h07 and other command-like bytes.
- R6: When the register is not armed, a control byte with low nibble 4'b0111 (interrupt control, for example 8'h07) leaves the mode and the mask unchanged. So does any byte that is neither a mode word nor an interrupt control word.
- R7: A mode word with bits 7:6 other than 2'b11 leaves bit-control mode, so all lines become inputs. It does not arm the register, and the mask and latch are kept.
- R8: A data read returns the latch bit on each output line and the `pin_in` bit on each input line.
- R9: Reads at offsets other than 0 return 0. Writes at offsets 1 and 3 change neither the latch, the mask nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register offset (0 data, 2 control) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| pin_in | input | 8 | Sampled pin levels |
| port_out | output | 8 | Output latch value |
| port_oe | output | 8 | Per-line output enable, 1 = driven |

## Verification
The assertions check the following on every cycle:
- the arm-then-mask handoff in the control sequencer;
- that ignored control bytes leave the mode and mask stable;
- the one-cycle latch load;
- that no line is driven outside bit-control mode;
- that stray offsets leave the pins alone.

The bench scenarios cover the things a single-cycle property does not express well:
- the per-line read-back mix under changing pin patterns;
- a mask byte that looks like an interrupt word;
- mode changes that keep the old mask;
- reset in the middle of a sequence, which drops a pending mask.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [1:0] {
    PMODE_OUT    = 2'b00,
    PMODE_IN     = 2'b01,
    PMODE_BIDIR  = 2'b10,
    PMODE_BITCTL = 2'b11
  } pmode_e;

  localparam logic [3:0] NIB_MODE_WORD = 4'b1111;
  localparam logic [3:0] NIB_IRQ_WORD  = 4'b0111;

  localparam pmode_e RESET_MODE = PMODE_IN;

endpackage

// File: rtl/pport_ctrl_seq.sv
module pport_ctrl_seq
  import pport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output pmode_e           mode,
  output logic [WIDTH-1:0] dir_mask
);

  logic armed;
  logic is_mode_word;
  logic is_irq_word;

  assign is_mode_word = (wdata[3:0] == NIB_MODE_WORD);
  assign is_irq_word  = (wdata[3:0] == NIB_IRQ_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= RESET_MODE;
      dir_mask <= '1;
      armed    <= 1'b0;
    end else if (wr_en) begin
      if (armed) begin
        dir_mask <= wdata;
        armed    <= 1'b0;
      end else if (is_mode_word) begin
        mode  <= pmode_e'(wdata[WIDTH-1:WIDTH-2]);
        armed <= (wdata[WIDTH-1:WIDTH-2] == 2'b11);
      end else if (is_irq_word) begin
        armed <= 1'b0;
      end
    end
  end

  // R4
  mask_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && armed) |=> (dir_mask == $past(wdata)) && !armed && $stable(mode));

  // R3
  arm_on_bitctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed && is_mode_word && wdata[WIDTH-1:WIDTH-2] == 2'b11)
      |=> armed && (mode == PMODE_BITCTL));

  // R6
  ignore_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed && !is_mode_word) |=> $stable(mode) && $stable(dir_mask) && !armed);

  // R7
  leave_bitctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed && is_mode_word && wdata[WIDTH-1:WIDTH-2] != 2'b11)
      |=> !armed && (mode != PMODE_BITCTL) && $stable(dir_mask));

endmodule

// File: rtl/pport_data_path.sv
module pport_data_path
  import pport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  input  pmode_e           mode,
  input  logic [WIDTH-1:0] dir_mask,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] port_out,
  output logic [WIDTH-1:0] port_oe,
  output logic [WIDTH-1:0] rd_mix
);

  logic [WIDTH-1:0] latch_q;
  logic             bit_mode;

  assign bit_mode = (mode == PMODE_BITCTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else if (wr_en) latch_q <= wdata;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    assign port_oe[i] = bit_mode & ~dir_mask[i];
    assign rd_mix[i]  = port_oe[i] ? latch_q[i] : pin_in[i];
  end

  assign port_out = latch_q;

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> port_out == $past(wdata));

  // R1
  no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_mode |-> port_oe == '0);

endmodule

// File: rtl/pport_bitctl.sv
module pport_bitctl
  import pport_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 2,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  port_out,
  output logic [WIDTH-1:0]  port_oe
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

  logic             data_wr, ctrl_wr, data_rd;
  pmode_e           mode;
  logic [WIDTH-1:0] dir_mask;
  logic [WIDTH-1:0] rd_mix;

  assign data_wr = bus_wr && (bus_addr == A_DATA);
  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign data_rd = bus_rd && (bus_addr == A_DATA);

  pport_ctrl_seq #(.WIDTH(WIDTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wdata    (bus_wdata),
    .mode     (mode),
    .dir_mask (dir_mask)
  );

  pport_data_path #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (data_wr),
    .wdata    (bus_wdata),
    .mode     (mode),
    .dir_mask (dir_mask),
    .pin_in   (pin_in),
    .port_out (port_out),
    .port_oe  (port_oe),
    .rd_mix   (rd_mix)
  );

  assign bus_rdata = data_rd ? rd_mix : '0;

  // R9
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != A_DATA && bus_addr != A_CTRL)
      |=> $stable(port_out) && $stable(port_oe) && $stable(mode));

endmodule

// File: tb/pport_bitctl_test.sv
module pport_bitctl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] port_out;
  logic [7:0] port_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pport_bitctl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .port_out(port_out), .port_oe(port_oe)
  );

  // {wr, addr, wdata, pin, exp_oe, exp_out, exp_rd}
  localparam int NV = 19;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 2'd2, 8'hCF, 8'h5A, 8'h00, 8'h00, 8'h5A}, // R3 armed, mask still all inputs
    {1'b1, 2'd2, 8'h0E, 8'hA5, 8'hF1, 8'h00, 8'h04}, // R4 mask
    {1'b1, 2'd0, 8'h3C, 8'hFF, 8'hF1, 8'h3C, 8'h3E}, // R2 R8
    {1'b1, 2'd2, 8'h07, 8'h00, 8'hF1, 8'h3C, 8'h30}, // R6 irq word
    {1'b1, 2'd2, 8'h00, 8'h0E, 8'hF1, 8'h3C, 8'h3E}, // R6 junk byte
    {1'b1, 2'd2, 8'hCF, 8'h00, 8'hF1, 8'h3C, 8'h30}, // R3 re-arm
    {1'b1, 2'd2, 8'h07, 8'hFF, 8'hF8, 8'h3C, 8'h3F}, // R5 07 as mask
    {1'b1, 2'd1, 8'h00, 8'h00, 8'hF8, 8'h3C, 8'h38}, // R9 offset 1
    {1'b1, 2'd3, 8'hFF, 8'h00, 8'hF8, 8'h3C, 8'h38}, // R9 offset 3
    {1'b1, 2'd2, 8'h4F, 8'h81, 8'h00, 8'h3C, 8'h81}, // R7 leave bit mode
    {1'b1, 2'd2, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h00}, // R7 not armed
    {1'b1, 2'd2, 8'hCF, 8'h00, 8'hF8, 8'h3C, 8'h38}, // R7 mask kept
    {1'b1, 2'd2, 8'h00, 8'h00, 8'hFF, 8'h3C, 8'h3C}, // R4 all outputs
    {1'b1, 2'd0, 8'hA5, 8'h5A, 8'hFF, 8'hA5, 8'hA5}, // R8 all latch
    {1'b1, 2'd2, 8'hCF, 8'h00, 8'hFF, 8'hA5, 8'hA5}, // R3
    {1'b1, 2'd2, 8'hFF, 8'h12, 8'h00, 8'hA5, 8'h12}, // R5 FF as mask
    {1'b1, 2'd0, 8'h66, 8'h34, 8'h00, 8'h66, 8'h34}, // R2 latch on inputs
    {1'b1, 2'd2, 8'h8F, 8'hC3, 8'h00, 8'h66, 8'hC3}, // R7 mode 10
    {1'b0, 2'd0, 8'h00, 8'h3C, 8'h00, 8'h66, 8'h3C}  // R8 idle read
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_check(string req, logic [7:0] pin, logic [7:0] eoe,
                            logic [7:0] eout, logic [7:0] erd);
    pin_in = pin; bus_addr = 2'd0; bus_rd = 1'b1;
    #1;
    check({req, " oe"}, port_oe, eoe);
    check({req, " out"}, port_out, eout);
    check({req, " rd"}, bus_rdata, erd);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_check("R1 reset", 8'h96, 8'h00, 8'h00, 8'h96);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) bus_write(VEC[i][41:40], VEC[i][39:32]);
      else @(negedge clk);
      read_check($sformatf("vec%0d", i), VEC[i][31:24], VEC[i][23:16],
                 VEC[i][15:8], VEC[i][7:0]);
    end

    // R9 read at control offset returns 0
    @(negedge clk);
    bus_addr = 2'd2; bus_rd = 1'b1; pin_in = 8'hFF;
    #1 check("R9 ctrl read", bus_rdata, 8'h00);
    bus_rd = 1'b0;

    // R1 reset mid-sequence drops pending mask
    bus_write(2'd2, 8'hCF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_check("R1 after reset", 8'h5A, 8'h00, 8'h00, 8'h5A);
    bus_write(2'd2, 8'h00);
    read_check("R6 not armed after reset", 8'h11, 8'h00, 8'h00, 8'h11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule